// File: doc/BRIEF.md
# H-Bridge Gate Sequencer with Dead Time

This block turns three logic controls (enable, direction, PWM) and a set of fault flags into on/off commands for the four transistors of a two-half-bridge motor driver. It also drives a tri-state diagnostic line. While enabled and healthy, the direction and PWM levels select one of three bridge patterns: forward, reverse or braking. Braking switches on both high sides.

Any change on direction or PWM switches off at once each transistor that the new pattern does not keep. A transistor that must newly turn on waits for a programmable dead time, counted in clock cycles from the `dead_cycles` input. A further edge during that wait restarts it. This keeps the two transistors of one half bridge from ever conducting together.

The faults have a fixed priority. Standby comes first, then the thermal, overvoltage and undervoltage faults, then the per-transistor short-circuit inhibits supplied by an external monitor.

The controller is a four-state machine:
- `ST_STANDBY` is entered on reset or when enable is low.
- `ST_FAULT` is entered when enabled and any of thermal, overvoltage or undervoltage is set.
- `ST_DEAD` is the turn-on wait, entered from `ST_STANDBY` or `ST_FAULT` on recovery, or from `ST_DRIVE` on an input edge. It returns to itself on a new edge.
- `ST_DRIVE` is steady drive, entered from `ST_DEAD` when the counter has expired.

Top module: `hbridge_gate_seq`

## Requirements
- R1: Standby. One clock edge after `en` is sampled low, `gate_on` is 0000, `gates_passive` is 1 and `diag_oe` is 0. This overrides every fault. The same values hold during reset.
- R2: Global faults. One clock edge after `en` is sampled high together with any of `flt_therm`, `flt_ov` or `flt_uv`, `gate_on` is 0000, `diag_oe` is 1 and `diag_level` is 0.
- R3: Forward pattern. With dir=0 and pwm=0, the settled `gate_on` is 4'b0110. The bit order is bit0 HS1, bit1 LS1, bit2 HS2, bit3 LS2.
- R4: Reverse pattern. With dir=1 and pwm=0, the settled `gate_on` is 4'b1001.
- R5: Braking pattern. With pwm=1, the settled `gate_on` is 4'b0101 for either dir. Toggling dir during braking leaves `gate_on` unchanged in every cycle.
- R6: Turn-off is immediate. At the clock edge that first samples a dir or pwm change, every transistor not in the new pattern turns off. A transistor that is in both the old and the new pattern stays on.
- R7: Turn-on is delayed. A transistor newly required turns on at the (D+1)-th clock edge after the edge that sampled the change, where D is `dead_cycles` at that edge. D ranges up to 2^DT_W-1.
- R8: The delay is retriggerable. A further dir or pwm change during the wait reloads the count, and the delay is measured from the latest change.
- R9: A set `sc_inhibit[i]` forces `gate_on[i]` to 0 in the same cycle, leaves the other gates unchanged and drives `diag_level` to 0 while `diag_oe` is 1.
- R10: When enabled with no fault and no inhibit, `diag_oe` is 1 and `diag_level` is 1.
- R11: Leaving standby or a global fault applies the same turn-on delay as R7, counted from the first edge that samples the healthy, enabled condition.
- R12: With `dead_cycles` equal to 0, a newly required transistor turns on at the first edge after the change edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Enable; low selects standby |
| dir | input | 1 | Direction select |
| pwm | input | 1 | PWM / braking control |
| flt_therm | input | 1 | Over-temperature fault |
| flt_ov | input | 1 | Overvoltage fault |
| flt_uv | input | 1 | Undervoltage fault |
| sc_inhibit | input | 4 | Per-transistor short-circuit inhibit (HS1, LS1, HS2, LS2) |
| dead_cycles | input | DT_W | Dead-time count D |
| gate_on | output | 4 | Gate on commands (HS1, LS1, HS2, LS2); 0 means sink |
| gates_passive | output | 1 | All gates in passive resistive state |
| diag_oe | output | 1 | Diagnostic output enable; 0 is high impedance |
| diag_level | output | 1 | Diagnostic level; 0 flags an error |

## Verification
The bench builds the block with DT_W=4. This makes the largest dead time, 15 cycles, cheap to walk cycle by cycle next to the zero-delay case. Short counts of 2 and 6 leave room to land a second edge inside a running wait and so exercise the restart. Each fault source, standby and recovery is replayed from a known settled pattern, so the expected gate vector at every cycle follows directly from the pattern tables and the D+1 rule.

// File: rtl/hbg_pkg.sv
package hbg_pkg;
    typedef enum logic [1:0] {
        ST_STANDBY,
        ST_FAULT,
        ST_DEAD,
        ST_DRIVE
    } seq_state_t;

    localparam int GATE_N = 4;
    localparam int HS1 = 0;
    localparam int LS1 = 1;
    localparam int HS2 = 2;
    localparam int LS2 = 3;
endpackage

// File: rtl/hbg_decode.sv
module hbg_decode
    import hbg_pkg::*;
(
    input  logic              dir,
    input  logic              pwm,
    output logic [GATE_N-1:0] pattern
);
    always_comb begin
        pattern = '0;
        if (pwm) begin
            pattern[HS1] = 1'b1;
            pattern[HS2] = 1'b1;
        end else if (dir) begin
            pattern[HS1] = 1'b1;
            pattern[LS2] = 1'b1;
        end else begin
            pattern[LS1] = 1'b1;
            pattern[HS2] = 1'b1;
        end
    end
endmodule

// File: rtl/hbg_dead_timer.sv
module hbg_dead_timer #(
    parameter int DT_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [DT_W-1:0] load_val,
    output logic            expired
);
    logic [DT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/hbg_out_stage.sv
module hbg_out_stage
    import hbg_pkg::*;
(
    input  seq_state_t        state,
    input  logic [GATE_N-1:0] gate_q,
    input  logic [GATE_N-1:0] sc_inhibit,
    output logic [GATE_N-1:0] gate_on,
    output logic              gates_passive,
    output logic              diag_oe,
    output logic              diag_level
);
    logic active;

    always_comb begin
        active        = (state == ST_DEAD) || (state == ST_DRIVE);
        gate_on       = active ? (gate_q & ~sc_inhibit) : '0;
        gates_passive = (state == ST_STANDBY);
        diag_oe       = (state != ST_STANDBY);
        diag_level    = active && (sc_inhibit == '0);
    end
endmodule

// File: rtl/hbridge_gate_seq.sv
module hbridge_gate_seq
    import hbg_pkg::*;
#(
    parameter int DT_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            dir,
    input  logic            pwm,
    input  logic            flt_therm,
    input  logic            flt_ov,
    input  logic            flt_uv,
    input  logic [3:0]      sc_inhibit,
    input  logic [DT_W-1:0] dead_cycles,
    output logic [3:0]      gate_on,
    output logic            gates_passive,
    output logic            diag_oe,
    output logic            diag_level
);
    seq_state_t        state_q, state_d;
    logic [GATE_N-1:0] gate_q, gate_d, target;
    logic              dir_q, pwm_q;
    logic              in_edge, flt_any, tmr_load, tmr_expired;

    assign in_edge = (dir != dir_q) || (pwm != pwm_q);
    assign flt_any = flt_therm || flt_ov || flt_uv;

    hbg_decode u_decode (
        .dir     (dir),
        .pwm     (pwm),
        .pattern (target)
    );

    hbg_dead_timer #(.DT_W(DT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (dead_cycles),
        .expired  (tmr_expired)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_STANDBY;
            gate_q  <= '0;
            dir_q   <= 1'b0;
            pwm_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            gate_q  <= gate_d;
            dir_q   <= dir;
            pwm_q   <= pwm;
        end
    end

    // Next state and gate plan
    always_comb begin
        state_d  = state_q;
        gate_d   = gate_q & target;
        tmr_load = 1'b0;
        if (!en) begin
            state_d = ST_STANDBY;
            gate_d  = '0;
        end else if (flt_any) begin
            state_d = ST_FAULT;
            gate_d  = '0;
        end else begin
            unique case (state_q)
                ST_STANDBY, ST_FAULT: begin
                    state_d  = ST_DEAD;
                    gate_d   = '0;
                    tmr_load = 1'b1;
                end
                ST_DRIVE: begin
                    if (in_edge) begin
                        state_d  = ST_DEAD;
                        tmr_load = 1'b1;
                    end else begin
                        gate_d = target;
                    end
                end
                ST_DEAD: begin
                    if (in_edge) begin
                        tmr_load = 1'b1;
                    end else if (tmr_expired) begin
                        state_d = ST_DRIVE;
                        gate_d  = target;
                    end
                end
            endcase
        end
    end

    // Outputs
    hbg_out_stage u_out (
        .state         (state_q),
        .gate_q        (gate_q),
        .sc_inhibit    (sc_inhibit),
        .gate_on       (gate_on),
        .gates_passive (gates_passive),
        .diag_oe       (diag_oe),
        .diag_level    (diag_level)
    );
endmodule

// File: rtl/hbg_seq_checker.sv
module hbg_seq_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       en,
    input logic       dir,
    input logic       pwm,
    input logic       flt_therm,
    input logic       flt_ov,
    input logic       flt_uv,
    input logic [3:0] sc_inhibit,
    input logic [3:0] gate_on,
    input logic       gates_passive,
    input logic       diag_oe,
    input logic       diag_level
);
    assert_standby_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (gates_passive && !diag_oe && gate_on == 4'b0000));

    assert_fault_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && (flt_therm || flt_ov || flt_uv)) |=>
        (gate_on == 4'b0000 && diag_oe && !diag_level));

    assert_no_shoot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_on[0] && gate_on[1]) && !(gate_on[2] && gate_on[3]));

    for (genvar i = 0; i < 4; i++) begin : g_rise
        assert_rise_after_wait_R7: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(gate_on[i]) && $stable(sc_inhibit[i])) |-> ($stable(dir) && $stable(pwm)));
    end

    assert_sc_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_on & sc_inhibit) == 4'b0000);

    assert_sc_diag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (diag_oe && sc_inhibit != 4'b0000) |-> !diag_level);

    assert_diag_ok_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (diag_oe && sc_inhibit == 4'b0000 && $past(en && !(flt_therm || flt_ov || flt_uv)))
        |-> diag_level);
endmodule

bind hbridge_gate_seq hbg_seq_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .en            (en),
    .dir           (dir),
    .pwm           (pwm),
    .flt_therm     (flt_therm),
    .flt_ov        (flt_ov),
    .flt_uv        (flt_uv),
    .sc_inhibit    (sc_inhibit),
    .gate_on       (gate_on),
    .gates_passive (gates_passive),
    .diag_oe       (diag_oe),
    .diag_level    (diag_level)
);

// File: tb/hbridge_gate_seq_tb.sv
module hbridge_gate_seq_tb;
    localparam int DT_W = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            en = 1'b1, dir = 1'b0, pwm = 1'b0;
    logic            flt_therm = 1'b0, flt_ov = 1'b0, flt_uv = 1'b0;
    logic [3:0]      sc_inhibit = 4'b0000;
    logic [DT_W-1:0] dead_cycles = 4'd3;
    logic [3:0]      gate_on;
    logic            gates_passive, diag_oe, diag_level;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    hbridge_gate_seq #(.DT_W(DT_W)) u_dut (
        .clk (clk), .rst_n (rst_n), .en (en), .dir (dir), .pwm (pwm),
        .flt_therm (flt_therm), .flt_ov (flt_ov), .flt_uv (flt_uv),
        .sc_inhibit (sc_inhibit), .dead_cycles (dead_cycles),
        .gate_on (gate_on), .gates_passive (gates_passive),
        .diag_oe (diag_oe), .diag_level (diag_level)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    endtask

    // Stimulus already applied at a negedge; the next posedge samples it.
    task automatic check_delay(input string tag, input int d, input logic [3:0] b, input logic [3:0] a);
        @(negedge clk); chk(tag, gate_on, b);
        repeat (d) begin @(negedge clk); chk(tag, gate_on, b); end
        @(negedge clk); chk(tag, gate_on, a);
    endtask

    task automatic t_reset_wake();
        @(negedge clk);
        chk("R1 reset gates", gate_on, 4'b0000);
        chk("R1 reset passive", gates_passive, 1'b1);
        chk("R1 reset diag_oe", diag_oe, 1'b0);
        rst_n = 1'b1;
        check_delay("R11 wake R3", 3, 4'b0000, 4'b0110);
        chk("R10 diag_oe", diag_oe, 1'b1);
        chk("R10 diag_level", diag_level, 1'b1);
    endtask

    task automatic t_fwd_rev();
        dead_cycles = 4'd2;
        @(negedge clk); dir = 1'b1;
        check_delay("R4 R6 R7 reverse", 2, 4'b0000, 4'b1001);
        chk("R10 diag after reverse", diag_level, 1'b1);
    endtask

    task automatic t_brake();
        @(negedge clk); pwm = 1'b1;
        check_delay("R5 R6 brake keep HS1", 2, 4'b0001, 4'b0101);
        @(negedge clk); dir = 1'b0;
        repeat (4) begin @(negedge clk); chk("R5 dir ignored in brake", gate_on, 4'b0101); end
        @(negedge clk); pwm = 1'b0;
        check_delay("R3 R6 leave brake keep HS2", 2, 4'b0100, 4'b0110);
    endtask

    task automatic t_retrigger();
        dead_cycles = 4'd6;
        @(negedge clk); pwm = 1'b1;
        repeat (3) begin @(negedge clk); chk("R8 first wait", gate_on, 4'b0100); end
        pwm = 1'b0;
        check_delay("R8 restarted wait", 6, 4'b0100, 4'b0110);
    endtask

    task automatic t_zero_and_max();
        dead_cycles = 4'd0;
        @(negedge clk); dir = 1'b1;
        check_delay("R12 zero delay", 0, 4'b0000, 4'b1001);
        dead_cycles = 4'd15;
        @(negedge clk); dir = 1'b0;
        check_delay("R7 max delay", 15, 4'b0000, 4'b0110);
        dead_cycles = 4'd2;
    endtask

    task automatic t_short();
        @(negedge clk); sc_inhibit = 4'b0100; #1;
        chk("R9 HS2 inhibited", gate_on, 4'b0010);
        chk("R9 diag low", diag_level, 1'b0);
        chk("R9 diag driven", diag_oe, 1'b1);
        @(negedge clk); sc_inhibit = 4'b0001; dir = 1'b1;
        check_delay("R9 HS1 inhibited reverse", 2, 4'b0000, 4'b1000);
        chk("R9 diag low reverse", diag_level, 1'b0);
        sc_inhibit = 4'b0000; #1;
        chk("R9 release", gate_on, 4'b1001);
        chk("R10 diag back high", diag_level, 1'b1);
    endtask

    task automatic t_fault(input int which);
        @(negedge clk);
        flt_therm = (which == 0); flt_ov = (which == 1); flt_uv = (which == 2);
        sc_inhibit = 4'b0010;
        @(negedge clk);
        chk("R2 fault gates", gate_on, 4'b0000);
        chk("R2 fault diag_oe", diag_oe, 1'b1);
        chk("R2 fault diag_level", diag_level, 1'b0);
        chk("R2 not passive", gates_passive, 1'b0);
        flt_therm = 1'b0; flt_ov = 1'b0; flt_uv = 1'b0; sc_inhibit = 4'b0000;
        check_delay("R11 fault recovery", 2, 4'b0000, 4'b1001);
    endtask

    task automatic t_standby();
        @(negedge clk); en = 1'b0; flt_ov = 1'b1;
        @(negedge clk);
        chk("R1 standby gates", gate_on, 4'b0000);
        chk("R1 standby passive", gates_passive, 1'b1);
        chk("R1 standby diag_oe", diag_oe, 1'b0);
        flt_ov = 1'b0; en = 1'b1;
        check_delay("R11 standby recovery", 2, 4'b0000, 4'b1001);
    endtask

    initial begin
        t_reset_wake();
        t_fwd_rev();
        t_brake();
        t_retrigger();
        t_zero_and_max();
        t_short();
        t_fault(0);
        t_fault(1);
        t_fault(2);
        t_standby();
        done = 1'b1;
        report();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end
endmodule